// File: doc/BRIEF.md
# Load/Store Operation Sequencing Unit

This unit carries one memory operation at a time through a fixed, forward-only series of handshake phases. An issue strobe brings in a 2-bit opcode and a signed immediate. The opcode picks load, store or load-with-update. The unit then raises one request line at a time. It moves to the next phase only when the go strobe that belongs to the raised request arrives. A go strobe with no matching request has no effect.

The unit captures the first operand and the second operand in separate registers. It forms the effective address from the first operand and the sign-extended immediate, and it latches load data when the address phase completes. It presents the captured values on the store-data and write-back outputs. The register file and memory sit outside the unit. Each of them answers a request with a single-cycle go pulse, together with any data that the go carries. Busy is high from the cycle after issue until the cycle after the final go.

Top module: `lsu_seq`

## Requirements
- R1: While rst_n is sampled low at a rising edge, the unit returns to idle. Busy and every request output are low in the following cycle, and they stay low while the unit is idle.
- R2: Opcode encodings are 2'b00 load, 2'b01 store and 2'b10 update. An issue with one of these encodings, seen while the unit is not busy, sets busy and rd1_req in the next cycle. An issue with 2'b11, or any issue seen while busy, is ignored: it changes neither the phase, the opcode nor the immediate.
- R3: A go strobe is honoured only while its own request is high. Any other go leaves the request outputs unchanged.
- R4: A load runs rd1_req, then addr_req, then wb1_req alone.
- R5: A store runs rd1_req, then rd2_req, then addr_req, then st_req. During st_req, st_data equals the value on rd2_data when rd2_go was honoured.
- R6: An update runs rd1_req, then addr_req, then wb1_req and wb2_req together. During that phase, wb2_data equals the effective address.
- R7: During addr_req, ea equals the rd1_data captured at the honoured rd1_go, plus the issue immediate sign-extended to XLEN. The result wraps modulo 2^XLEN.
- R8: For load and update, wb1_data equals the ld_data that was present when addr_go was honoured.
- R9: At most one of rd1_req, rd2_req, addr_req, st_req and wb1_req is high at any time. wb2_req is high only together with wb1_req. Busy is high exactly when some request is high.
- R10: The go that completes the last phase (st_go or wb_go) clears busy in the next cycle, and a new issue is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld | input | 1 | Issue strobe |
| issue_op | input | 2 | Opcode: 00 load, 01 store, 10 update |
| issue_imm | input | IMM_W | Signed immediate offset |
| busy | output | 1 | Operation in flight |
| rd1_req | output | 1 | Request for the first operand |
| rd1_go | input | 1 | First operand valid |
| rd1_data | input | XLEN | First operand (base) |
| rd2_req | output | 1 | Request for the second operand (store only) |
| rd2_go | input | 1 | Second operand valid |
| rd2_data | input | XLEN | Second operand (store data) |
| addr_req | output | 1 | Effective address ready |
| addr_go | input | 1 | Address accepted, load data valid |
| ea | output | XLEN | Effective address |
| ld_data | input | XLEN | Load data returned by memory |
| st_req | output | 1 | Store request |
| st_go | input | 1 | Store accepted |
| st_data | output | XLEN | Store data |
| wb1_req | output | 1 | First write-back request |
| wb2_req | output | 1 | Second write-back request (update only) |
| wb_go | input | 1 | Write-back accepted |
| wb1_data | output | XLEN | Loaded value |
| wb2_data | output | XLEN | Updated base (effective address) |

## Verification
The assertions assume that data inputs are only meaningful in the cycle of their go pulse. They also assume that the environment may pulse any go in any cycle, and that reset can arrive at any point, including mid-operation. The stimulus keeps within this. It answers each request after a random delay. During that delay it pulses random non-matching go strobes and stray issue strobes with random opcodes and immediates. It changes the data inputs freely except in the cycle of a honoured go. Directed cases add the reserved opcode, reset in the address phase, the extreme immediates and a wrapping base address.

// File: rtl/lsu_seq_pkg.sv
// Package: shared types for the load/store sequencing unit.
// Assumes: 2-bit opcode field; phase encoding is internal only.
package lsu_seq_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_UPDATE = 2'b10,
        OP_RSVD   = 2'b11
    } lsu_op_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RD1  = 3'd1,
        PH_RD2  = 3'd2,
        PH_ADDR = 3'd3,
        PH_ST   = 3'd4,
        PH_WB   = 3'd5
    } lsu_phase_e;

    // True for the three defined opcodes.
    function automatic logic op_is_valid(input logic [1:0] op);
        return op != OP_RSVD;
    endfunction

endpackage

// File: rtl/lsu_phase_fsm.sv
// Module: lsu_phase_fsm
// Holds the current phase and the opcode of the operation in flight.
// Advances only forward, and only on the go strobe that matches the
// current phase. Unused encodings fall back to idle.
// Assumes: synchronous active-low reset.
module lsu_phase_fsm
    import lsu_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_vld,
    input  logic [1:0] issue_op,
    input  logic       rd1_go,
    input  logic       rd2_go,
    input  logic       addr_go,
    input  logic       st_go,
    input  logic       wb_go,
    output lsu_phase_e phase,
    output lsu_op_e    cur_op,
    output logic       acc_issue,
    output logic       cap_rd1,
    output logic       cap_rd2,
    output logic       cap_addr
);

    lsu_phase_e nxt;

    // Capture strobes: a go counts only in its own phase.
    always_comb begin
        acc_issue = (phase == PH_IDLE) && issue_vld && op_is_valid(issue_op);
        cap_rd1   = (phase == PH_RD1)  && rd1_go;
        cap_rd2   = (phase == PH_RD2)  && rd2_go;
        cap_addr  = (phase == PH_ADDR) && addr_go;
    end

    // Next-phase selection along the path chosen by the opcode.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: if (acc_issue) nxt = PH_RD1;
            PH_RD1:  if (rd1_go)    nxt = (cur_op == OP_STORE) ? PH_RD2 : PH_ADDR;
            PH_RD2:  if (rd2_go)    nxt = PH_ADDR;
            PH_ADDR: if (addr_go)   nxt = (cur_op == OP_STORE) ? PH_ST : PH_WB;
            PH_ST:   if (st_go)     nxt = PH_IDLE;
            PH_WB:   if (wb_go)     nxt = PH_IDLE;
            default:                nxt = PH_IDLE;
        endcase
    end

    // Phase and opcode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cur_op <= OP_LOAD;
        end else begin
            phase <= nxt;
            if (acc_issue) cur_op <= lsu_op_e'(issue_op);
        end
    end

endmodule

// File: rtl/lsu_operand_regs.sv
// Module: lsu_operand_regs
// Operand, immediate and load-data registers plus the address adder.
// Each register loads only on its capture strobe from the phase FSM.
// Assumes: XLEN > IMM_W.
module lsu_operand_regs #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_issue,
    input  logic             cap_rd1,
    input  logic             cap_rd2,
    input  logic             cap_addr,
    input  logic [IMM_W-1:0] issue_imm,
    input  logic [XLEN-1:0]  rd1_data,
    input  logic [XLEN-1:0]  rd2_data,
    input  logic [XLEN-1:0]  ld_data,
    output logic [XLEN-1:0]  ea,
    output logic [XLEN-1:0]  st_data,
    output logic [XLEN-1:0]  wb1_data
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [IMM_W-1:0] imm_q;
    logic [XLEN-1:0]  base_q;
    logic [XLEN-1:0]  src2_q;
    logic [XLEN-1:0]  ldv_q;

    // Register loads on the capture strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_q  <= '0;
            base_q <= '0;
            src2_q <= '0;
            ldv_q  <= '0;
        end else begin
            if (acc_issue) imm_q  <= issue_imm;
            if (cap_rd1)   base_q <= rd1_data;
            if (cap_rd2)   src2_q <= rd2_data;
            if (cap_addr)  ldv_q  <= ld_data;
        end
    end

    // Effective address: base plus sign-extended immediate.
    always_comb begin
        ea       = base_q + {{EXT_W{imm_q[IMM_W-1]}}, imm_q};
        st_data  = src2_q;
        wb1_data = ldv_q;
    end

endmodule

// File: rtl/lsu_req_decode.sv
// Module: lsu_req_decode
// Turns the phase and opcode into the request lines and busy.
// Purely combinational; at most one phase request is active at a time.
module lsu_req_decode
    import lsu_seq_pkg::*;
(
    input  lsu_phase_e phase,
    input  lsu_op_e    cur_op,
    output logic       busy,
    output logic       rd1_req,
    output logic       rd2_req,
    output logic       addr_req,
    output logic       st_req,
    output logic       wb1_req,
    output logic       wb2_req
);

    // Request decode.
    always_comb begin
        busy     = (phase != PH_IDLE);
        rd1_req  = (phase == PH_RD1);
        rd2_req  = (phase == PH_RD2);
        addr_req = (phase == PH_ADDR);
        st_req   = (phase == PH_ST);
        wb1_req  = (phase == PH_WB);
        wb2_req  = (phase == PH_WB) && (cur_op == OP_UPDATE);
    end

endmodule

// File: rtl/lsu_seq.sv
// Module: lsu_seq (top)
// Sequences one load, store or load-with-update operation through
// paired request/go handshakes. The register file and memory answer
// each request with a single-cycle go pulse plus any data.
// Assumes: synchronous active-low reset; data is valid with its go.
module lsu_seq
    import lsu_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [1:0]       issue_op,
    input  logic [IMM_W-1:0] issue_imm,
    output logic             busy,
    output logic             rd1_req,
    input  logic             rd1_go,
    input  logic [XLEN-1:0]  rd1_data,
    output logic             rd2_req,
    input  logic             rd2_go,
    input  logic [XLEN-1:0]  rd2_data,
    output logic             addr_req,
    input  logic             addr_go,
    output logic [XLEN-1:0]  ea,
    input  logic [XLEN-1:0]  ld_data,
    output logic             st_req,
    input  logic             st_go,
    output logic [XLEN-1:0]  st_data,
    output logic             wb1_req,
    output logic             wb2_req,
    input  logic             wb_go,
    output logic [XLEN-1:0]  wb1_data,
    output logic [XLEN-1:0]  wb2_data
);

    lsu_phase_e phase;
    lsu_op_e    cur_op;
    logic       acc_issue, cap_rd1, cap_rd2, cap_addr;

    lsu_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_vld(issue_vld),
        .issue_op (issue_op),
        .rd1_go   (rd1_go),
        .rd2_go   (rd2_go),
        .addr_go  (addr_go),
        .st_go    (st_go),
        .wb_go    (wb_go),
        .phase    (phase),
        .cur_op   (cur_op),
        .acc_issue(acc_issue),
        .cap_rd1  (cap_rd1),
        .cap_rd2  (cap_rd2),
        .cap_addr (cap_addr)
    );

    lsu_operand_regs #(.XLEN(XLEN), .IMM_W(IMM_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_issue(acc_issue),
        .cap_rd1  (cap_rd1),
        .cap_rd2  (cap_rd2),
        .cap_addr (cap_addr),
        .issue_imm(issue_imm),
        .rd1_data (rd1_data),
        .rd2_data (rd2_data),
        .ld_data  (ld_data),
        .ea       (ea),
        .st_data  (st_data),
        .wb1_data (wb1_data)
    );

    lsu_req_decode u_dec (
        .phase   (phase),
        .cur_op  (cur_op),
        .busy    (busy),
        .rd1_req (rd1_req),
        .rd2_req (rd2_req),
        .addr_req(addr_req),
        .st_req  (st_req),
        .wb1_req (wb1_req),
        .wb2_req (wb2_req)
    );

    // Second write-back carries the updated base.
    assign wb2_data = ea;

endmodule

// File: rtl/lsu_seq_chk.sv
// Module: lsu_seq_chk
// Port-level protocol checks for lsu_seq, attached by bind.
module lsu_seq_chk #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_vld,
    input logic [1:0]       issue_op,
    input logic [IMM_W-1:0] issue_imm,
    input logic             busy,
    input logic             rd1_req,
    input logic             rd1_go,
    input logic             rd2_req,
    input logic             rd2_go,
    input logic             addr_req,
    input logic             addr_go,
    input logic [XLEN-1:0]  ea,
    input logic             st_req,
    input logic             st_go,
    input logic [XLEN-1:0]  st_data,
    input logic             wb1_req,
    input logic             wb2_req,
    input logic             wb_go,
    input logic [XLEN-1:0]  wb1_data
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(rd1_req || rd2_req || addr_req || st_req || wb1_req || wb2_req));

    // R2
    issue_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && issue_vld && issue_op != 2'b11) |=> rd1_req);

    // R2
    rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && issue_vld && issue_op == 2'b11) |=> !busy);

    // R3
    rd1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_req && !rd1_go) |=> rd1_req);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_req && !addr_go) |=> (addr_req && $stable(ea)));

    // R5
    rd2_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_req && rd1_go && !rd2_req && !addr_req) |=> (rd2_req || addr_req));

    // R5
    st_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_go) |=> (st_req && $stable(st_data)));

    // R9
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd1_req, rd2_req, addr_req, st_req, wb1_req}) && (!wb2_req || wb1_req));

    // R9
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (rd1_req || rd2_req || addr_req || st_req || wb1_req));

    // R8
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb1_req && !wb_go) |=> (wb1_req && $stable(wb1_data)));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_req && st_go) || (wb1_req && wb_go)) |=> !busy);

endmodule

bind lsu_seq lsu_seq_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_vld(issue_vld),
    .issue_op (issue_op),
    .issue_imm(issue_imm),
    .busy     (busy),
    .rd1_req  (rd1_req),
    .rd1_go   (rd1_go),
    .rd2_req  (rd2_req),
    .rd2_go   (rd2_go),
    .addr_req (addr_req),
    .addr_go  (addr_go),
    .ea       (ea),
    .st_req   (st_req),
    .st_go    (st_go),
    .st_data  (st_data),
    .wb1_req  (wb1_req),
    .wb2_req  (wb2_req),
    .wb_go    (wb_go),
    .wb1_data (wb1_data)
);

// File: tb/lsu_seq_bench.sv
`timescale 1ns/1ps
module lsu_seq_bench;

    localparam int XLEN  = 32;
    localparam int IMM_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_vld = 1'b0;
    logic [1:0]       issue_op = '0;
    logic [IMM_W-1:0] issue_imm = '0;
    logic             busy, rd1_req, rd2_req, addr_req, st_req, wb1_req, wb2_req;
    logic             rd1_go = 1'b0, rd2_go = 1'b0, addr_go = 1'b0, st_go = 1'b0, wb_go = 1'b0;
    logic [XLEN-1:0]  rd1_data = '0, rd2_data = '0, ld_data = '0;
    logic [XLEN-1:0]  ea, st_data, wb1_data, wb2_data;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lsu_seq #(.XLEN(XLEN), .IMM_W(IMM_W)) u_lsu_seq (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_op(issue_op),
        .issue_imm(issue_imm), .busy(busy), .rd1_req(rd1_req), .rd1_go(rd1_go),
        .rd1_data(rd1_data), .rd2_req(rd2_req), .rd2_go(rd2_go), .rd2_data(rd2_data),
        .addr_req(addr_req), .addr_go(addr_go), .ea(ea), .ld_data(ld_data),
        .st_req(st_req), .st_go(st_go), .st_data(st_data), .wb1_req(wb1_req),
        .wb2_req(wb2_req), .wb_go(wb_go), .wb1_data(wb1_data), .wb2_data(wb2_data)
    );

    // Expected request vectors {rd1,rd2,addr,st,wb1,wb2,busy}.
    localparam logic [6:0] V_IDLE = 7'b0000000;
    localparam logic [6:0] V_RD1  = 7'b1000001;
    localparam logic [6:0] V_RD2  = 7'b0100001;
    localparam logic [6:0] V_ADDR = 7'b0010001;
    localparam logic [6:0] V_ST   = 7'b0001001;
    localparam logic [6:0] V_WBL  = 7'b0000101;
    localparam logic [6:0] V_WBU  = 7'b0000111;

    function automatic logic [XLEN-1:0] exp_ea(input logic [XLEN-1:0] b, input logic [IMM_W-1:0] i);
        return b + {{(XLEN-IMM_W){i[IMM_W-1]}}, i};
    endfunction

    function automatic logic [6:0] reqs();
        return {rd1_req, rd2_req, addr_req, st_req, wb1_req, wb2_req, busy};
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Idle for a random few cycles while pulsing go strobes other than
    // the one numbered 'keep' (0 rd1,1 rd2,2 addr,3 st,4 wb) plus stray
    // issues; the request vector must not move.
    task automatic noise(input int keep, input logic [6:0] expv, input string tag);
        int n = $urandom_range(0, 3);
        for (int k = 0; k < n; k++) begin
            logic [4:0] g = 5'($urandom);
            g[keep] = 1'b0;
            {wb_go, st_go, addr_go, rd2_go, rd1_go} = g;
            issue_vld = 1'($urandom);
            issue_op  = 2'($urandom);
            issue_imm = IMM_W'($urandom);
            rd1_data  = $urandom; rd2_data = $urandom; ld_data = $urandom;
            @(negedge clk);
            chk(tag, XLEN'(reqs()), XLEN'(expv));
        end
        {wb_go, st_go, addr_go, rd2_go, rd1_go} = '0;
        issue_vld = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [IMM_W-1:0] imm,
                          input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                          input logic [XLEN-1:0] ld);
        issue_vld = 1'b1; issue_op = op; issue_imm = imm;
        @(negedge clk);
        issue_vld = 1'b0; issue_op = 2'($urandom); issue_imm = IMM_W'($urandom);
        chk("R2 issue", XLEN'(reqs()), XLEN'(V_RD1));
        noise(0, V_RD1, "R3 rd1 wait");
        rd1_data = a; rd1_go = 1'b1;
        @(negedge clk);
        rd1_go = 1'b0; rd1_data = $urandom;
        if (op == 2'b01) begin
            chk("R5 rd2 phase", XLEN'(reqs()), XLEN'(V_RD2));
            noise(1, V_RD2, "R3 rd2 wait");
            rd2_data = b; rd2_go = 1'b1;
            @(negedge clk);
            rd2_go = 1'b0; rd2_data = $urandom;
        end
        chk(op == 2'b01 ? "R5 addr phase" : "R4 addr phase", XLEN'(reqs()), XLEN'(V_ADDR));
        chk("R7 ea", ea, exp_ea(a, imm));
        noise(2, V_ADDR, "R3 addr wait");
        chk("R7 ea held", ea, exp_ea(a, imm));
        ld_data = ld; addr_go = 1'b1;
        @(negedge clk);
        addr_go = 1'b0; ld_data = $urandom;
        if (op == 2'b01) begin
            chk("R5 st phase", XLEN'(reqs()), XLEN'(V_ST));
            chk("R5 st_data", st_data, b);
            noise(3, V_ST, "R3 st wait");
            st_go = 1'b1;
        end else begin
            chk(op == 2'b10 ? "R6 wb phase" : "R4 wb phase", XLEN'(reqs()),
                XLEN'(op == 2'b10 ? V_WBU : V_WBL));
            chk("R8 wb1_data", wb1_data, ld);
            if (op == 2'b10) chk("R6 wb2_data", wb2_data, exp_ea(a, imm));
            noise(4, op == 2'b10 ? V_WBU : V_WBL, "R3 wb wait");
            wb_go = 1'b1;
        end
        @(negedge clk);
        st_go = 1'b0; wb_go = 1'b0;
        chk("R10 done", XLEN'(reqs()), XLEN'(V_IDLE));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", XLEN'(reqs()), XLEN'(V_IDLE));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", XLEN'(reqs()), XLEN'(V_IDLE));

        // R2: reserved opcode ignored
        issue_vld = 1'b1; issue_op = 2'b11; issue_imm = 12'h7ff;
        @(negedge clk);
        issue_vld = 1'b0;
        chk("R2 reserved", XLEN'(reqs()), XLEN'(V_IDLE));

        // Directed: each mode, extreme immediates, wrapping base.
        run_op(2'b00, 12'h800, 32'h0000_0010, 32'h0, 32'hdead_beef);
        run_op(2'b01, 12'h7ff, 32'hffff_ff00, 32'h1234_5678, 32'h0);
        run_op(2'b10, 12'hfff, 32'h0000_0000, 32'h0, 32'hcafe_f00d);
        run_op(2'b10, 12'h001, 32'hffff_ffff, 32'h0, 32'h5555_aaaa);

        // R10: back-to-back issue right after completion
        run_op(2'b01, 12'h004, 32'h100, 32'h0bad_cafe, 32'h0);
        run_op(2'b00, 12'h000, 32'h200, 32'h0, 32'h1);

        // R1: reset in the address phase
        issue_vld = 1'b1; issue_op = 2'b10; issue_imm = 12'h010;
        @(negedge clk);
        issue_vld = 1'b0; rd1_go = 1'b1; rd1_data = 32'h40;
        @(negedge clk);
        rd1_go = 1'b0;
        chk("R6 addr before reset", XLEN'(reqs()), XLEN'(V_ADDR));
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-op reset", XLEN'(reqs()), XLEN'(V_IDLE));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", XLEN'(reqs()), XLEN'(V_IDLE));

        // Random operations
        for (int t = 0; t < 60; t++) begin
            logic [1:0] op = 2'($urandom_range(0, 2));
            run_op(op, IMM_W'($urandom), $urandom, $urandom, $urandom);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule